// File: doc/BRIEF.md
# Accelerator Command Stream Decoder

This block parses a stream of 32-bit command words for a neural-network accelerator and turns it into configuration register writes and operation triggers. A command is either a single header word, or a header word followed by one 32-bit payload word. The header holds a 16-bit code and a 16-bit parameter. Setting commands update a bank of persistent configuration entries, and the compute engines read those entries through a lookup port. Operation commands produce a one-cycle issue pulse that carries the kind and the parameter.

The decoder keeps one count of outstanding kernel operations and one of outstanding DMA operations. Completion pulses from the engines lower these counts. A wait command holds the input stream until the matching count has dropped to the requested level. A stop command halts parsing and raises a done flag. An illegal payload mode halts parsing and raises an error flag. Both flags stay set until reset.

Top module: `cmd_stream_decoder`

## Requirements
- R1: A header word is split as follows. Bits [31:16] are the parameter. Bits [15:14] are the payload mode: 00 means no payload and 01 means one payload word follows. Bits [9:0] are the opcode. Opcodes for the no-payload class: 0x000 stop, 0x001 convolution, 0x002 depthwise, 0x003 pooling, 0x004 elementwise, 0x005 DMA start, 0x006 kernel wait, 0x007 DMA wait. A no-payload opcode with bit 8 set is a setting.
- R2: A no-payload setting produces a write pulse with the following values: reg_cls_o=0, reg_addr_o set to the opcode, reg_data_o set to the zero-extended parameter, and reg_aux_o=0. The pulse appears in the cycle after the header is accepted.
- R3: A mode-01 header produces no write when it is accepted. The decoder then waits for the payload word for as long as it takes. The write (reg_cls_o=1, reg_addr_o set to the opcode, reg_data_o set to the payload, reg_aux_o set to the header parameter) appears in the cycle after the payload is accepted. A payload word is never decoded as a command.
- R4: Each write is stored in bank entry {class, opcode[CFG_IDX_W-1:0]} as {aux, data}. The entry keeps its value until a later write to the same entry, and operations in between do not change it. cfg_rd_data_o returns the entry selected by cfg_rd_cls_i and cfg_rd_idx_i. After reset every entry is zero.
- R5: An operation opcode (0x001 to 0x005) produces op_valid_o in the cycle after it is accepted, with op_kind_o set to opcode[2:0] and op_param_o set to the parameter. For DMA start, bits [3:0] of the parameter are the mode and bits [15:4] are the channel. For pooling, parameter 0 means max and 1 means average.
- R6: Kernel operations (kinds 1 to 4) and DMA start each raise their own outstanding count by one on issue. The matching completion pulse lowers the count by one. A completion pulse while the count is zero has no effect. busy_o is high while a payload or wait is pending or while either count is non-zero.
- R7: A kernel wait holds word_ready_o low until the outstanding kernel count is no greater than the full 16-bit parameter.
- R8: A DMA wait holds word_ready_o low until the outstanding DMA count is no greater than parameter bits [3:0]. Parameter bits [15:4] are ignored.
- R9: Opcode 0x000 with parameter 0xFFFF sets done_o and drops word_ready_o until reset. Opcode 0x000 with any other parameter is ignored.
- R10: Payload mode 10 or 11 sets err_o, drops word_ready_o until reset, and produces no write or issue.
- R11: An operation header whose outstanding count is at its maximum (2^CNT_W-1) is not accepted until a completion pulse frees room.
- R12: A no-payload opcode that is neither a setting nor one of 0x000 to 0x007 is consumed with no write, no issue and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| word_valid_i | input | 1 | Command word valid |
| word_i | input | 32 | Command word |
| word_ready_o | output | 1 | Decoder accepts word_i |
| reg_we_o | output | 1 | Register write pulse |
| reg_cls_o | output | 1 | 0 = no-payload setting, 1 = payload setting |
| reg_addr_o | output | 10 | Setting opcode |
| reg_data_o | output | 32 | Written value |
| reg_aux_o | output | 16 | Header parameter of a payload setting |
| op_valid_o | output | 1 | Operation issue pulse |
| op_kind_o | output | 3 | Operation kind (opcode[2:0]) |
| op_param_o | output | 16 | Operation parameter |
| kern_done_i | input | 1 | One kernel operation completed |
| dma_done_i | input | 1 | One DMA operation completed |
| cfg_rd_cls_i | input | 1 | Bank read class |
| cfg_rd_idx_i | input | CFG_IDX_W | Bank read index |
| cfg_rd_data_o | output | 48 | Selected entry {aux, data} |
| busy_o | output | 1 | Work pending |
| done_o | output | 1 | Stop command seen (sticky) |
| err_o | output | 1 | Illegal payload mode seen (sticky) |

## Verification
Writes, issues and the done and error flags are registered, so each one shows in the cycle after the edge that accepts its completing word. The bank read port shows the new value from that same cycle. The bench drives words on falling edges and captures every result on the falling edge that follows the accepting rising edge. A completion pulse lowers its count on the next rising edge, and a satisfied wait releases ready one edge later. For that reason the bench checks that ready is low over several falling edges before it sends completion pulses, and then waits for the held word to be taken.

// File: rtl/cmd_dec_pkg.sv
package cmd_dec_pkg;
  localparam logic [9:0] OPC_STOP  = 10'h000;
  localparam logic [9:0] OPC_CONV  = 10'h001;
  localparam logic [9:0] OPC_DMA   = 10'h005;
  localparam logic [9:0] OPC_KWAIT = 10'h006;
  localparam logic [9:0] OPC_DWAIT = 10'h007;
  localparam logic [15:0] STOP_PRM = 16'hFFFF;
  localparam int SET_BIT = 8;

  typedef enum logic [2:0] {S_HDR, S_PAY, S_WAIT, S_STOP, S_ERR} dec_state_e;

  typedef struct packed {
    logic        illegal;
    logic        has_pay;
    logic        is_set;
    logic        is_op;
    logic        is_kwait;
    logic        is_dwait;
    logic        is_stop;
    logic [9:0]  opc;
    logic [15:0] prm;
  } hdr_t;
endpackage

// File: rtl/cmd_hdr_decode.sv
module cmd_hdr_decode
  import cmd_dec_pkg::*;
(
  input  logic [31:0] word_i,
  output hdr_t        hdr_o
);
  logic [1:0] mode;
  logic       np;

  always_comb begin
    mode          = word_i[15:14];
    np            = (mode == 2'b00);
    hdr_o.opc     = word_i[9:0];
    hdr_o.prm     = word_i[31:16];
    hdr_o.illegal = mode[1];
    hdr_o.has_pay = (mode == 2'b01);
    hdr_o.is_set  = np && word_i[SET_BIT];
    hdr_o.is_op   = np && (word_i[9:0] >= OPC_CONV) && (word_i[9:0] <= OPC_DMA);
    hdr_o.is_kwait = np && (word_i[9:0] == OPC_KWAIT);
    hdr_o.is_dwait = np && (word_i[9:0] == OPC_DWAIT);
    hdr_o.is_stop = np && (word_i[9:0] == OPC_STOP) && (word_i[31:16] == STOP_PRM);
  end
endmodule

// File: rtl/cmd_op_counter.sv
module cmd_op_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             dec_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             full_o
);
  logic dec_ok;

  assign dec_ok = dec_i && (cnt_o != '0);
  assign full_o = (cnt_o == '1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else if (inc_i && !dec_ok && !full_o) cnt_o <= cnt_o + 1'b1;
    else if (dec_ok && !inc_i) cnt_o <= cnt_o - 1'b1;
  end
endmodule

// File: rtl/cmd_cfg_bank.sv
module cmd_cfg_bank #(
  parameter int IDX_W = 4,
  parameter int DW    = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic             cls_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    data_i,
  input  logic             rd_cls_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [DW-1:0]    rd_data_o
);
  localparam int DEPTH = 1 << IDX_W;

  logic [1:0][DEPTH-1:0][DW-1:0] mem_q;

  for (genvar c = 0; c < 2; c++) begin : g_cls
    for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) mem_q[c][e] <= '0;
        else if (we_i && (cls_i == c[0]) && (idx_i == e[IDX_W-1:0])) mem_q[c][e] <= data_i;
      end
    end
  end

  assign rd_data_o = mem_q[rd_cls_i][rd_idx_i];
endmodule

// File: rtl/cmd_stream_decoder.sv
module cmd_stream_decoder
  import cmd_dec_pkg::*;
#(
  parameter int CFG_IDX_W = 4,
  parameter int CNT_W     = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 word_valid_i,
  input  logic [31:0]          word_i,
  output logic                 word_ready_o,
  output logic                 reg_we_o,
  output logic                 reg_cls_o,
  output logic [9:0]           reg_addr_o,
  output logic [31:0]          reg_data_o,
  output logic [15:0]          reg_aux_o,
  output logic                 op_valid_o,
  output logic [2:0]           op_kind_o,
  output logic [15:0]          op_param_o,
  input  logic                 kern_done_i,
  input  logic                 dma_done_i,
  input  logic                 cfg_rd_cls_i,
  input  logic [CFG_IDX_W-1:0] cfg_rd_idx_i,
  output logic [47:0]          cfg_rd_data_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 err_o
);
  localparam int N_KIND = 2;  // 0 kernel, 1 DMA
  localparam int CFG_W  = 48;

  hdr_t       hdr;
  dec_state_e state_q, state_d;
  logic [9:0]  pend_opc_q;
  logic [15:0] pend_prm_q;
  logic        wait_dma_q;
  logic [15:0] wait_thr_q;

  logic [N_KIND-1:0][CNT_W-1:0] cnt_q;
  logic [N_KIND-1:0]            cnt_full, inc, dec;
  logic hdr_is_dma, op_block, acc, hdr_acc, wait_ok;
  logic [15:0]      thr_eff;
  logic [CNT_W-1:0] wcnt;

  logic        wr_en, wr_cls, iss;
  logic [9:0]  wr_addr;
  logic [31:0] wr_data;
  logic [15:0] wr_aux, iss_prm;
  logic [2:0]  iss_kind;

  cmd_hdr_decode u_dec (.word_i(word_i), .hdr_o(hdr));

  assign hdr_is_dma   = (hdr.opc == OPC_DMA);
  assign op_block     = hdr.is_op && cnt_full[hdr_is_dma];
  assign word_ready_o = ((state_q == S_HDR) && !op_block) || (state_q == S_PAY);
  assign acc          = word_valid_i && word_ready_o;
  assign hdr_acc      = acc && (state_q == S_HDR);

  for (genvar k = 0; k < N_KIND; k++) begin : g_cnt
    assign inc[k] = hdr_acc && !hdr.illegal && hdr.is_op && (hdr_is_dma == (k == 1));
    assign dec[k] = (k == 1) ? dma_done_i : kern_done_i;
    cmd_op_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (inc[k]),
      .dec_i (dec[k]),
      .cnt_o (cnt_q[k]),
      .full_o(cnt_full[k])
    );
  end

  // DMA waits only honour the low nibble of the parameter
  assign thr_eff = wait_dma_q ? {12'h000, wait_thr_q[3:0]} : wait_thr_q;
  assign wcnt    = cnt_q[wait_dma_q];
  assign wait_ok = 32'(wcnt) <= 32'(thr_eff);

  always_comb begin
    state_d  = state_q;
    wr_en    = 1'b0;
    wr_cls   = 1'b0;
    wr_addr  = '0;
    wr_data  = '0;
    wr_aux   = '0;
    iss      = 1'b0;
    iss_kind = '0;
    iss_prm  = '0;
    unique case (state_q)
      S_HDR: begin
        if (acc) begin
          if (hdr.illegal) state_d = S_ERR;
          else if (hdr.has_pay) state_d = S_PAY;
          else if (hdr.is_set) begin
            wr_en   = 1'b1;
            wr_addr = hdr.opc;
            wr_data = 32'(hdr.prm);
          end else if (hdr.is_op) begin
            iss      = 1'b1;
            iss_kind = hdr.opc[2:0];
            iss_prm  = hdr.prm;
          end else if (hdr.is_kwait || hdr.is_dwait) state_d = S_WAIT;
          else if (hdr.is_stop) state_d = S_STOP;
        end
      end
      S_PAY: begin
        if (acc) begin
          wr_en   = 1'b1;
          wr_cls  = 1'b1;
          wr_addr = pend_opc_q;
          wr_data = word_i;
          wr_aux  = pend_prm_q;
          state_d = S_HDR;
        end
      end
      S_WAIT: if (wait_ok) state_d = S_HDR;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_HDR;
      pend_opc_q <= '0;
      pend_prm_q <= '0;
      wait_dma_q <= 1'b0;
      wait_thr_q <= '0;
      reg_we_o   <= 1'b0;
      reg_cls_o  <= 1'b0;
      reg_addr_o <= '0;
      reg_data_o <= '0;
      reg_aux_o  <= '0;
      op_valid_o <= 1'b0;
      op_kind_o  <= '0;
      op_param_o <= '0;
    end else begin
      state_q <= state_d;
      if (hdr_acc && hdr.has_pay && !hdr.illegal) begin
        pend_opc_q <= hdr.opc;
        pend_prm_q <= hdr.prm;
      end
      if (hdr_acc && (hdr.is_kwait || hdr.is_dwait)) begin
        wait_dma_q <= hdr.is_dwait;
        wait_thr_q <= hdr.prm;
      end
      reg_we_o   <= wr_en;
      op_valid_o <= iss;
      if (wr_en) begin
        reg_cls_o  <= wr_cls;
        reg_addr_o <= wr_addr;
        reg_data_o <= wr_data;
        reg_aux_o  <= wr_aux;
      end
      if (iss) begin
        op_kind_o  <= iss_kind;
        op_param_o <= iss_prm;
      end
    end
  end

  cmd_cfg_bank #(.IDX_W(CFG_IDX_W), .DW(CFG_W)) u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (wr_en),
    .cls_i    (wr_cls),
    .idx_i    (wr_addr[CFG_IDX_W-1:0]),
    .data_i   ({wr_aux, wr_data}),
    .rd_cls_i (cfg_rd_cls_i),
    .rd_idx_i (cfg_rd_idx_i),
    .rd_data_o(cfg_rd_data_o)
  );

  assign busy_o = (state_q == S_PAY) || (state_q == S_WAIT) || (cnt_q != '0);
  assign done_o = (state_q == S_STOP);
  assign err_o  = (state_q == S_ERR);
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
module cmd_stream_decoder_chk
  import cmd_dec_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             word_ready_o,
  input logic             reg_we_o,
  input logic             reg_cls_o,
  input logic             op_valid_o,
  input logic             done_o,
  input logic             err_o,
  input logic             kern_done_i,
  input logic             dma_done_i,
  input dec_state_e       state_q,
  input logic [CNT_W-1:0] kcnt,
  input logic [CNT_W-1:0] dcnt
);
  p_one_out_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(reg_we_o && op_valid_o));
  p_pay_whole_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && reg_cls_o) |-> ($past(state_q) == S_PAY));
  p_kwait_stall_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_WAIT) |-> !word_ready_o);
  p_done_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !word_ready_o));
  p_err_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (err_o && !word_ready_o));
  p_k_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((kcnt == '0) && kern_done_i) |=> (kcnt <= CNT_W'(1)));
  p_d_no_underflow_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((dcnt == '0) && dma_done_i) |=> (dcnt <= CNT_W'(1)));
  p_flags_excl_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .word_ready_o(word_ready_o),
  .reg_we_o    (reg_we_o),
  .reg_cls_o   (reg_cls_o),
  .op_valid_o  (op_valid_o),
  .done_o      (done_o),
  .err_o       (err_o),
  .kern_done_i (kern_done_i),
  .dma_done_i  (dma_done_i),
  .state_q     (state_q),
  .kcnt        (cnt_q[0]),
  .dcnt        (cnt_q[1])
);

// File: tb/cmd_stream_decoder_bench.sv
module cmd_stream_decoder_bench;
  timeunit 1ns;
  timeprecision 1ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic word_valid = 1'b0;
  logic [31:0] word = '0;
  logic kern_done = 1'b0, dma_done = 1'b0;
  logic rd_cls = 1'b0;
  logic [3:0] rd_idx = '0;
  logic word_ready, reg_we, reg_cls, op_valid, busy, done, err;
  logic [9:0] reg_addr;
  logic [31:0] reg_data;
  logic [15:0] reg_aux, op_param;
  logic [2:0] op_kind;
  logic [47:0] rd_data;

  int n_chk = 0, n_fail = 0;
  logic s_we, s_cls, s_op;
  logic [9:0] s_addr;
  logic [31:0] s_data;
  logic [15:0] s_aux, s_prm;
  logic [2:0] s_kind;

  always #4 clk = ~clk;

  cmd_stream_decoder u_cmd_stream_decoder (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(word_valid), .word_i(word),
    .word_ready_o(word_ready), .reg_we_o(reg_we), .reg_cls_o(reg_cls),
    .reg_addr_o(reg_addr), .reg_data_o(reg_data), .reg_aux_o(reg_aux),
    .op_valid_o(op_valid), .op_kind_o(op_kind), .op_param_o(op_param),
    .kern_done_i(kern_done), .dma_done_i(dma_done), .cfg_rd_cls_i(rd_cls),
    .cfg_rd_idx_i(rd_idx), .cfg_rd_data_o(rd_data), .busy_o(busy),
    .done_o(done), .err_o(err)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input logic [63:0] act, input logic [63:0] exp);
    chk(act === exp, req, act, exp);
  endtask

  task automatic do_reset();
    word_valid = 1'b0; kern_done = 1'b0; dma_done = 1'b0;
    @(negedge clk) rst_n = 1'b0;
    @(negedge clk) @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
  endtask

  // waits at falling edges until the held word is taken, then snapshots results
  task automatic finish_acc();
    int n = 0;
    #1;
    while (!word_ready && n < 2000) begin @(negedge clk); #1; n++; end
    if (n >= 2000) chk(1'b0, "accept", 0, 1);
    @(negedge clk);
    word_valid = 1'b0;
    s_we = reg_we; s_cls = reg_cls; s_addr = reg_addr; s_data = reg_data; s_aux = reg_aux;
    s_op = op_valid; s_kind = op_kind; s_prm = op_param;
  endtask

  task automatic send(input logic [31:0] w);
    @(negedge clk);
    word_valid = 1'b1; word = w;
    finish_acc();
  endtask

  task automatic hold(input logic [31:0] w);
    word_valid = 1'b1; word = w;
    #1;
  endtask

  task automatic pulse_k();
    @(negedge clk) kern_done = 1'b1;
    @(negedge clk) kern_done = 1'b0;
  endtask

  task automatic pulse_d();
    @(negedge clk) dma_done = 1'b1;
    @(negedge clk) dma_done = 1'b0;
  endtask

  function automatic logic [31:0] np(input logic [9:0] opc, input logic [15:0] prm);
    return {prm, 6'b000000, opc};
  endfunction

  function automatic logic [31:0] pl(input logic [9:0] opc, input logic [15:0] prm);
    return {prm, 6'b010000, opc};
  endfunction

  task automatic read_cfg(input logic cls, input logic [3:0] idx, output logic [47:0] v);
    rd_cls = cls; rd_idx = idx; #1; v = rd_data;
  endtask

  task automatic t_reset();
    logic [47:0] v;
    chk_eq("R6 reset busy", busy, 0);
    chk_eq("R9 reset done", done, 0);
    chk_eq("R10 reset err", err, 0);
    chk_eq("R1 reset ready", word_ready, 1);
    chk_eq("R5 reset issue", {reg_we, op_valid}, 0);
    read_cfg(0, 3, v);
    chk_eq("R4 reset bank", v, 0);
  endtask

  task automatic t_setting();
    logic [47:0] v;
    send(np(10'h103, 16'hABCD));
    chk_eq("R2 write pulse", {s_we, s_cls, s_op}, 3'b100);
    chk_eq("R2 addr", s_addr, 10'h103);
    chk_eq("R2 data", s_data, 32'h0000ABCD);
    chk_eq("R2 aux", s_aux, 0);
    read_cfg(0, 3, v);
    chk_eq("R4 stored", v, 48'h0000_0000ABCD);
  endtask

  task automatic t_payload();
    logic [47:0] v;
    bit seen = 0;
    send(pl(10'h00A, 16'h0007));
    chk_eq("R3 no write on header", s_we, 0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (reg_we) seen = 1;
    end
    chk_eq("R3 no partial write", seen, 0);
    chk_eq("R6 busy while payload due", busy, 1);
    send(32'hDEADBEEF);
    chk_eq("R3 payload write", {s_we, s_cls}, 2'b11);
    chk_eq("R3 payload addr", s_addr, 10'h00A);
    chk_eq("R3 payload data", s_data, 32'hDEADBEEF);
    chk_eq("R3 payload aux", s_aux, 16'h0007);
    read_cfg(1, 4'hA, v);
    chk_eq("R4 payload stored", v, 48'h0007_DEADBEEF);
    send(pl(10'h005, 16'h0001));
    send(32'hFFFF0000);  // looks like stop, must be data
    chk_eq("R3 payload not decoded", {s_we, s_cls, done}, 3'b110);
    chk_eq("R3 payload data2", s_data, 32'hFFFF0000);
  endtask

  task automatic t_ops();
    logic [47:0] v;
    send(np(10'h001, 16'h0000));
    chk_eq("R5 conv", {s_op, s_we, s_kind, s_prm}, {1'b1, 1'b0, 3'd1, 16'h0});
    send(np(10'h003, 16'h0001));
    chk_eq("R5 avg pool", {s_op, s_kind, s_prm}, {1'b1, 3'd3, 16'h1});
    send(np(10'h004, 16'h0002));
    chk_eq("R5 elementwise", {s_op, s_kind, s_prm}, {1'b1, 3'd4, 16'h2});
    send(np(10'h005, 16'h0013));
    chk_eq("R5 dma ch1 mode3", {s_op, s_kind, s_prm}, {1'b1, 3'd5, 16'h0013});
    chk_eq("R6 busy with ops", busy, 1);
    read_cfg(0, 3, v);
    chk_eq("R4 persists across ops", v, 48'h0000_0000ABCD);
  endtask

  task automatic t_kwait();
    logic [47:0] v;
    send(np(10'h006, 16'h0001));  // kernel count is 3
    hold(np(10'h104, 16'h0055));
    chk_eq("R7 stall", word_ready, 0);
    pulse_k();
    #1 chk_eq("R7 stall at 2", word_ready, 0);
    pulse_k();
    finish_acc();
    chk_eq("R7 released", {s_we, s_addr}, {1'b1, 10'h104});
    pulse_k();
    pulse_k();  // spurious at zero
    send(np(10'h002, 16'h0000));
    send(np(10'h006, 16'h0000));
    hold(np(10'h103, 16'h1234));
    @(negedge clk); @(negedge clk); #1;
    chk_eq("R6 no underflow, R7 stall", word_ready, 0);
    pulse_k();
    finish_acc();
    read_cfg(0, 3, v);
    chk_eq("R4 overwritten", v, 48'h0000_00001234);
  endtask

  task automatic t_dwait();
    send(np(10'h007, 16'hFFF0));  // dma count 1, threshold 0
    hold(np(10'h105, 16'h0001));
    @(negedge clk); @(negedge clk); #1;
    chk_eq("R8 upper bits ignored", word_ready, 0);
    pulse_d();
    finish_acc();
    chk_eq("R8 released", {s_we, s_addr}, {1'b1, 10'h105});
    chk_eq("R6 idle", busy, 0);
  endtask

  task automatic t_full();
    for (int i = 0; i < 15; i++) send(np(10'h005, 16'h0000));
    @(negedge clk);
    hold(np(10'h005, 16'h0021));
    chk_eq("R11 full stall", word_ready, 0);
    pulse_d();
    finish_acc();
    chk_eq("R11 issued after room", {s_op, s_prm}, {1'b1, 16'h0021});
    for (int i = 0; i < 15; i++) pulse_d();
    #1 chk_eq("R6 drained", busy, 0);
  endtask

  task automatic t_ignored();
    send(np(10'h020, 16'h0005));
    chk_eq("R12 ignored", {s_we, s_op, done, err, busy}, 0);
    send(np(10'h000, 16'h1234));
    chk_eq("R9 stop needs FFFF", {s_we, s_op, done}, 0);
    #1 chk_eq("R12 still ready", word_ready, 1);
  endtask

  task automatic t_stop();
    send(np(10'h000, 16'hFFFF));
    #1 chk_eq("R9 done", {done, word_ready}, 2'b10);
    @(negedge clk); #1;
    chk_eq("R9 done sticky", {done, word_ready}, 2'b10);
  endtask

  task automatic t_illegal(input logic [1:0] mode);
    do_reset();
    send({16'h0001, mode, 4'b0000, 10'h103});
    #1 chk_eq("R10 err", {err, word_ready, s_we, s_op}, 4'b1000);
    @(negedge clk); #1;
    chk_eq("R10 err sticky", {err, done}, 2'b10);
  endtask

  initial begin
    #(8 * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    t_reset();
    t_setting();
    t_payload();
    t_ops();
    t_kwait();
    t_dwait();
    t_full();
    t_ignored();
    t_stop();
    t_illegal(2'b10);
    t_illegal(2'b11);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule